// File: doc/BRIEF.md
# DMA Channel Interrupt Register Unit

This unit collects the interrupt sources of one DMA channel into a software-visible register set and drives a single level-sensitive interrupt line. The transfer engine sends single-cycle event pulses: source and destination descriptor completion, whole-transfer completion, pause, and five kinds of bus or count fault. Each pulse latches a bit in a 12-bit status word. Software clears those bits by writing ones to them.

A mask word decides which latched bits reach the interrupt line. Software cannot write the mask directly. Instead it writes ones to an unmask port to clear mask bits, or to a mask port to set them. Two 8-bit counters tally descriptor completions from the source side and the destination side. Each counter is cleared when software reads it. When a counter wraps, it latches a status bit of its own. An access to an unused offset latches an invalid-access status bit.

Register offsets are word indices on `reg_addr`. Only whole 32-bit words are accessed. Read data is combinational and is valid in the same cycle that `reg_rd` is high.

Top module: `dma_irq_regs`

## Requirements
- R1: After a synchronous active-low reset the status word reads 0, the mask reads 0xFFF, both counters read 0 and `irq` is low.
- R2: Each event pulse sets its status bit at the next clock edge, as follows. `ev_fault[0..4]` set bits 3, 6, 7, 8 and 9. `ev_xfer_done` sets bit 10 and `ev_paused` sets bit 11. The status word is read at word offset 0.
- R3: Writing offset 0 clears every status bit whose write-data bit is 1. Status bits above 11 always read 0.
- R4: If a hardware event sets a status bit in the same cycle that software writes 1 to clear it, the bit stays set.
- R5: The mask reads at offset 1 and ignores writes there. A write to offset 2 clears the mask bits that are 1 in the data. A write to offset 3 sets them. Offsets 2 and 3 read as 0.
- R6: `irq` is high exactly when some status bit is set and its mask bit is clear. It follows any change of status or mask at the same clock edge that makes the change.
- R7: Each `ev_src_done` pulse increments the source counter (offset 4) and sets status bit 1. Each `ev_dst_done` pulse increments the destination counter (offset 5) and sets status bit 2.
- R8: An increment from 255 to 0 sets status bit 4 for the source counter, or status bit 5 for the destination counter.
- R9: The counters ignore writes. A read returns the current count and clears the counter to 0 at that clock edge.
- R10: If an increment and a read of the same counter happen in the same cycle, the counter holds 1 afterwards.
- R11: A read or write at any offset above 5 sets status bit 0. Such a read returns 0 and such a write changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Word offset |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, combinational |
| ev_src_done | input | 1 | Source descriptor completed |
| ev_dst_done | input | 1 | Destination descriptor completed |
| ev_xfer_done | input | 1 | Transfer completed |
| ev_paused | input | 1 | Channel paused |
| ev_fault | input | 5 | Byte-count overflow, source/destination descriptor read error, data read error, data write error |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets four corner cases:
- **Set and clear in the same cycle.** A design that let the clear win would lose the event. The status read-back would then show 0 where 0x400 is expected.
- **Increment and read-clear in the same cycle.** A design that let the clear win would read 0 afterwards where 1 is expected. A design that ignored the clear would read 3.
- **Full 256-step counter wrap.** A missing or misplaced overflow bit shows up as a wrong status value, with 0x012 expected.
- **Masking and unmasking.** The bench checks that the interrupt line drops while a bit is masked and rises as soon as it is unmasked. It also checks that unused offsets read 0 and flag the invalid-access bit without changing other state.

// File: rtl/dma_irq_pkg.sv
// Package: shared bit positions, register offsets and decode type of the
// DMA channel interrupt unit. Assumes a word-indexed register window.
package dma_irq_pkg;

    localparam int STAT_W  = 12;
    localparam int FAULT_W = 5;
    localparam int NUM_CNT = 2;

    // Status bit positions (software decodes these)
    localparam int B_INVALID   = 0;
    localparam int B_SRC_DONE  = 1;
    localparam int B_DST_DONE  = 2;
    localparam int B_BYTE_OVF  = 3;
    localparam int B_SRC_WRAP  = 4;
    localparam int B_DST_WRAP  = 5;
    localparam int B_SRC_DRD   = 6;
    localparam int B_DST_DRD   = 7;
    localparam int B_DATA_RD   = 8;
    localparam int B_DATA_WR   = 9;
    localparam int B_XFER_DONE = 10;
    localparam int B_PAUSED    = 11;

    // Word offsets
    localparam int OFF_STATUS  = 0;
    localparam int OFF_MASK    = 1;
    localparam int OFF_ENABLE  = 2;
    localparam int OFF_DISABLE = 3;
    localparam int OFF_SRC_CNT = 4;
    localparam int OFF_DST_CNT = 5;

    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_DISABLE = 3'd3,
        SEL_SRC_CNT = 3'd4,
        SEL_DST_CNT = 3'd5,
        SEL_NONE    = 3'd6
    } reg_sel_e;

endpackage

// File: rtl/dma_irq_decode.sv
// Module: dma_irq_decode
// Maps a word offset onto a register select. Assumes whole-word accesses;
// every offset not listed decodes to SEL_NONE.
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Purpose: pure offset compare, no state
    always_comb begin
        if (addr == ADDR_W'(OFF_STATUS))       sel = SEL_STATUS;
        else if (addr == ADDR_W'(OFF_MASK))    sel = SEL_MASK;
        else if (addr == ADDR_W'(OFF_ENABLE))  sel = SEL_ENABLE;
        else if (addr == ADDR_W'(OFF_DISABLE)) sel = SEL_DISABLE;
        else if (addr == ADDR_W'(OFF_SRC_CNT)) sel = SEL_SRC_CNT;
        else if (addr == ADDR_W'(OFF_DST_CNT)) sel = SEL_DST_CNT;
        else                                   sel = SEL_NONE;
    end

endmodule

// File: rtl/dma_irq_counter.sv
// Module: dma_irq_counter
// Completion counter with clear-on-read. An increment in the same cycle
// as a clear leaves the count at 1. The wrap flag pulses combinationally
// when an increment rolls the all-ones value over to zero.
module dma_irq_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Purpose: flag a roll-over that is not masked by a simultaneous clear
    always_comb wrap = inc && !clr && (count == CNT_MAX);

    // Purpose: count register with clear, increment and merged case
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (inc && clr) count <= CNT_ONE;
        else if (clr)        count <= '0;
        else if (inc)        count <= count + CNT_ONE;
    end

endmodule

// File: rtl/dma_irq_status.sv
// Module: dma_irq_status
// Holds the sticky status word, the mask word and the registered
// interrupt line. A set beats a write-1-to-clear of the same bit.
// The mask resets to all ones and changes only through the unmask and
// mask ports.
module dma_irq_status #(
    parameter int STAT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] w1c_vec,
    input  logic              unmask_wr,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_bits,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);

    logic [STAT_W-1:0] status_next;
    logic [STAT_W-1:0] mask_next;

    // Purpose: next status, set dominates clear
    always_comb status_next = (status & ~w1c_vec) | set_vec;

    // Purpose: next mask from the unmask and mask ports
    always_comb begin
        mask_next = mask;
        if (unmask_wr) mask_next = mask_next & ~mask_bits;
        if (mask_wr)   mask_next = mask_next | mask_bits;
    end

    // Purpose: state registers; irq is registered from the next values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '1;
            irq    <= 1'b0;
        end else begin
            status <= status_next;
            mask   <= mask_next;
            irq    <= |(status_next & ~mask_next);
        end
    end

endmodule

// File: rtl/dma_irq_regs.sv
// Module: dma_irq_regs (top)
// Register-mapped interrupt unit of one DMA channel. Assumes single-cycle
// read and write strobes and single-cycle event pulses. Read data is
// combinational while reg_rd is high.
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_src_done,
    input  logic              ev_dst_done,
    input  logic              ev_xfer_done,
    input  logic              ev_paused,
    input  logic [FAULT_W-1:0] ev_fault,
    output logic              irq
);

    reg_sel_e          sel;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] w1c_vec;
    logic [STAT_W-1:0] wbits;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [NUM_CNT-1:0] cnt_clr;
    logic [NUM_CNT-1:0] cnt_wrap;
    logic [CNT_W-1:0]  cnt_val [NUM_CNT];
    logic [CNT_W-1:0]  src_cnt;
    logic [CNT_W-1:0]  dst_cnt;
    logic              bad_access;
    logic              wdata_unused;

    assign wbits        = reg_wdata[STAT_W-1:0];
    assign wdata_unused = ^reg_wdata[DATA_W-1:STAT_W];

    dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (reg_addr),
        .sel  (sel)
    );

    // Purpose: counter increment and clear-on-read strobes
    always_comb begin
        cnt_inc = {ev_dst_done, ev_src_done};
        cnt_clr = {reg_rd && (sel == SEL_DST_CNT), reg_rd && (sel == SEL_SRC_CNT)};
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        dma_irq_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .clr   (cnt_clr[g]),
            .count (cnt_val[g]),
            .wrap  (cnt_wrap[g])
        );
    end

    assign src_cnt = cnt_val[0];
    assign dst_cnt = cnt_val[1];

    // Purpose: flag any access that decodes to no register
    always_comb bad_access = (reg_rd || reg_wr) && (sel == SEL_NONE);

    // Purpose: gather hardware set requests into status bit positions
    always_comb begin
        set_vec              = '0;
        set_vec[B_INVALID]   = bad_access;
        set_vec[B_SRC_DONE]  = ev_src_done;
        set_vec[B_DST_DONE]  = ev_dst_done;
        set_vec[B_BYTE_OVF]  = ev_fault[0];
        set_vec[B_SRC_WRAP]  = cnt_wrap[0];
        set_vec[B_DST_WRAP]  = cnt_wrap[1];
        set_vec[B_SRC_DRD]   = ev_fault[1];
        set_vec[B_DST_DRD]   = ev_fault[2];
        set_vec[B_DATA_RD]   = ev_fault[3];
        set_vec[B_DATA_WR]   = ev_fault[4];
        set_vec[B_XFER_DONE] = ev_xfer_done;
        set_vec[B_PAUSED]    = ev_paused;
    end

    // Purpose: software clear request for the status word
    always_comb w1c_vec = (reg_wr && sel == SEL_STATUS) ? wbits : '0;

    dma_irq_status #(.STAT_W(STAT_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .w1c_vec   (w1c_vec),
        .unmask_wr (reg_wr && sel == SEL_ENABLE),
        .mask_wr   (reg_wr && sel == SEL_DISABLE),
        .mask_bits (wbits),
        .status    (status_q),
        .mask      (mask_q),
        .irq       (irq)
    );

    // Purpose: read mux, zero-extended; write-only and unmapped read 0
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (sel)
                SEL_STATUS:  reg_rdata[STAT_W-1:0] = status_q;
                SEL_MASK:    reg_rdata[STAT_W-1:0] = mask_q;
                SEL_SRC_CNT: reg_rdata[CNT_W-1:0]  = src_cnt;
                SEL_DST_CNT: reg_rdata[CNT_W-1:0]  = dst_cnt;
                default:     reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_irq_chk.sv
// Module: dma_irq_chk
// Property checker bound into dma_irq_regs. Observes ports and the
// internal status, mask, counter and request signals.
module dma_irq_chk
    import dma_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [2:0]         sel,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [STAT_W-1:0]  status,
    input logic [STAT_W-1:0]  mask,
    input logic [STAT_W-1:0]  set_vec,
    input logic [STAT_W-1:0]  w1c_vec,
    input logic [NUM_CNT-1:0] cnt_inc,
    input logic [NUM_CNT-1:0] cnt_clr,
    input logic [CNT_W-1:0]   src_cnt,
    input logic               irq
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(status & ~mask));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(w1c_vec & ~set_vec)) |=> ((status & $past(w1c_vec & ~set_vec)) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R5
    unmask_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_ENABLE && !(reg_wr && sel == SEL_DISABLE))
        |=> ((mask & $past(reg_wdata[STAT_W-1:0])) == '0));

    // R5
    mask_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_DISABLE)
        |=> ((mask & $past(reg_wdata[STAT_W-1:0])) == $past(reg_wdata[STAT_W-1:0])));

    // R8
    src_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc[0] && !cnt_clr[0] && src_cnt == CMAX) |=> status[B_SRC_WRAP]);

    // R10
    inc_clr_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc[0] && cnt_clr[0]) |=> (src_cnt == CNT_W'(1)));

    // R11
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel == SEL_NONE) |-> (reg_rdata == '0));

endmodule

bind dma_irq_regs dma_irq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .sel       (sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .status    (status_q),
    .mask      (mask_q),
    .set_vec   (set_vec),
    .w1c_vec   (w1c_vec),
    .cnt_inc   (cnt_inc),
    .cnt_clr   (cnt_clr),
    .src_cnt   (src_cnt),
    .irq       (irq)
);

// File: tb/dma_irq_regs_bench.sv
module dma_irq_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_src_done = 1'b0;
    logic        ev_dst_done = 1'b0;
    logic        ev_xfer_done = 1'b0;
    logic        ev_paused = 1'b0;
    logic [4:0]  ev_fault = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_regs u_dma_irq_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_rd       (reg_rd),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ev_src_done  (ev_src_done),
        .ev_dst_done  (ev_dst_done),
        .ev_xfer_done (ev_xfer_done),
        .ev_paused    (ev_paused),
        .ev_fault     (ev_fault),
        .irq          (irq)
    );

    typedef struct packed {
        logic [1:0]  op;   // 0 write, 1 read and compare
        logic [3:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t TBL [NVEC] = '{
        '{2'd1, 4'd0,  32'h0,        32'h0,   8'd1},  // R1 status
        '{2'd1, 4'd1,  32'h0,        32'hFFF, 8'd1},  // R1 mask
        '{2'd1, 4'd4,  32'h0,        32'h0,   8'd1},  // R1 counter
        '{2'd0, 4'd1,  32'h0,        32'h0,   8'd5},  // R5 mask write ignored
        '{2'd1, 4'd1,  32'h0,        32'hFFF, 8'd5},
        '{2'd0, 4'd2,  32'h0F0,      32'h0,   8'd5},  // R5 unmask
        '{2'd1, 4'd1,  32'h0,        32'hF0F, 8'd5},
        '{2'd1, 4'd2,  32'h0,        32'h0,   8'd5},  // R5 port reads 0
        '{2'd0, 4'd3,  32'h030,      32'h0,   8'd5},  // R5 mask
        '{2'd1, 4'd1,  32'h0,        32'hF3F, 8'd5},
        '{2'd0, 4'd0,  32'hFFFFFFFF, 32'h0,   8'd3},  // R3 clear all
        '{2'd1, 4'd0,  32'h0,        32'h0,   8'd3},
        '{2'd1, 4'd9,  32'h0,        32'h0,   8'd11}, // R11 unmapped read
        '{2'd1, 4'd0,  32'h0,        32'h1,   8'd11},
        '{2'd0, 4'd0,  32'h1,        32'h0,   8'd3},  // R3 clear bit 0
        '{2'd1, 4'd0,  32'h0,        32'h0,   8'd3},
        '{2'd0, 4'd15, 32'hFFF,      32'h0,   8'd11}, // R11 unmapped write
        '{2'd1, 4'd0,  32'h0,        32'h1,   8'd11},
        '{2'd1, 4'd1,  32'h0,        32'hF3F, 8'd11}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic dd, input logic x, input logic p, input logic [4:0] f);
        ev_src_done = s; ev_dst_done = dd; ev_xfer_done = x; ev_paused = p; ev_fault = f;
        @(negedge clk);
        ev_src_done = 0; ev_dst_done = 0; ev_xfer_done = 0; ev_paused = 0; ev_fault = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (TBL[i].op == 2'd0) wr(TBL[i].addr, TBL[i].wd);
            else begin
                rd(TBL[i].addr, d);
                check($sformatf("R%0d vec%0d", TBL[i].req, i), d, TBL[i].exp);
            end
        end
        wr(0, 32'h1);

        // R5 unmask everything
        wr(2, 32'hFFF);
        rd(1, d); check("R5 mask cleared", d, 32'h0);

        // R2 all engine events except descriptor done
        pulse(0, 0, 1, 1, 5'b11111);
        check("R6 irq on", {31'b0, irq}, 32'h1);
        rd(0, d); check("R2 event bits", d, 32'hFC8);
        wr(0, 32'hFFF);
        check("R6 irq off", {31'b0, irq}, 32'h0);
        rd(0, d); check("R3 cleared", d, 32'h0);

        // R6 masked source then unmask
        wr(3, 32'h400);
        pulse(0, 0, 1, 0, 5'b0);
        check("R6 masked", {31'b0, irq}, 32'h0);
        wr(2, 32'h400);
        check("R6 unmasked", {31'b0, irq}, 32'h1);
        wr(0, 32'h400);
        check("R6 cleared", {31'b0, irq}, 32'h0);

        // R4 set and clear in the same cycle
        pulse(0, 0, 1, 0, 5'b0);
        ev_xfer_done = 1'b1;
        wr(0, 32'h400);
        ev_xfer_done = 1'b0;
        rd(0, d); check("R4 set wins", d, 32'h400);
        wr(0, 32'h400);

        // R7 / R9 counters
        repeat (3) pulse(1, 0, 0, 0, 5'b0);
        rd(0, d); check("R7 src done bit", d, 32'h002);
        wr(4, 32'hAA);
        rd(4, d); check("R7 src count", d, 32'h3);
        rd(4, d); check("R9 clear on read", d, 32'h0);
        pulse(0, 1, 0, 0, 5'b0);
        wr(5, 32'hAA);
        rd(5, d); check("R9 dst write ignored", d, 32'h1);
        rd(0, d); check("R7 dst done bit", d, 32'h006);
        wr(0, 32'hFFF);

        // R8 wrap of the source counter
        repeat (256) pulse(1, 0, 0, 0, 5'b0);
        rd(0, d); check("R8 wrap bit", d, 32'h012);
        rd(4, d); check("R8 count wrapped", d, 32'h0);
        wr(0, 32'hFFF);

        // R10 increment and read-clear together
        repeat (2) pulse(1, 0, 0, 0, 5'b0);
        ev_src_done = 1'b1;
        rd(4, d);
        ev_src_done = 1'b0;
        check("R10 read value", d, 32'h2);
        rd(4, d); check("R10 merged count", d, 32'h1);

        // R1 reset in mid-run
        pulse(0, 0, 1, 0, 5'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(0, d); check("R1 status after reset", d, 32'h0);
        rd(1, d); check("R1 mask after reset", d, 32'hFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule